// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block holds renamed instructions until their operands are available. Each one then goes to execution, oldest first within its class. Every incoming instruction carries the following:

- an operation class (integer, floating point or branch);
- a sequence number that orders it against its neighbours;
- up to two source physical registers;
- an optional destination physical register.

A register-indexed ready table records which physical registers still wait on a producer. An entry's source starts out ready when the register is already available, or when it is woken in the same cycle.

When an execution unit finishes, the block sees a broadcast of the destination register. Every waiting source that names that register becomes ready. Each cycle the queue picks the ready entries it can issue. Each class has its own per-cycle limit, and a shared total limit also applies. Entries that issue leave the queue. A squash gives a sequence number and removes every entry younger than it.

Physical register indices form a single flat space of `NREG` registers, shared by integer and floating-point values. Any partitioning of that space is the concern of rename.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_count` equals DEPTH, `full` is 0, `in_ready` is 1 and no issue slot is valid. Every register in the ready table reads as available.
- R2: An instruction is accepted when `in_valid` and `in_ready` are both high. `in_ready` is low whenever the queue is full or `sq_valid` is high. A refused instruction leaves the queue unchanged.
- R3: `free_count` gives the number of empty entries, and `full` is high exactly when it is zero.
- R4: The class codes are 0 for integer, 1 for floating point and 2 for branch. Per cycle at most W_BR branch, W_INT integer and W_FP floating-point entries issue, and at most W_TOT entries issue in total. Classes claim the shared total in a fixed order: branch, then integer, then floating point.
- R5: Within a class the oldest ready entries issue first. A is older than B when (A−B) mod 2^SEQW has its top bit set. Issue slots fill from slot 0 upward with no gaps: branch grants first, then integer, then floating point, each class in age order.
- R6: A source of a new entry is ready at insertion in any of three cases: it is unused, its register reads as available in the ready table, or `wk_valid` names its register in the same cycle.
- R7: A wakeup on `wk_reg` marks every queued source that names that register as ready. An entry can issue from the cycle after its last source becomes ready.
- R8: Accepting an instruction with `in_dst_vld` set marks its destination register as unavailable. A wakeup marks the register available. When both touch the same register in one cycle, the register ends up unavailable.
- R9: An issued entry is freed at the end of its issue cycle. `free_count` in the next cycle includes its slot.
- R10: In a cycle with `sq_valid` high, every queued entry younger than `sq_seq` is removed and older or equal entries stay. No slot issues in that cycle.
- R11: An entry accepted in a cycle cannot issue in that same cycle. Issue is decided only from entries held in the queue at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New instruction offered |
| in_cls | input | 2 | Class code: 0 integer, 1 floating point, 2 branch |
| in_seq | input | SEQW | Sequence number of the new instruction |
| in_src0_vld | input | 1 | First source is used |
| in_src0 | input | RW | First source physical register |
| in_src1_vld | input | 1 | Second source is used |
| in_src1 | input | RW | Second source physical register |
| in_dst_vld | input | 1 | Instruction writes a destination |
| in_dst | input | RW | Destination physical register |
| in_ready | output | 1 | Queue can accept an instruction this cycle |
| free_count | output | FW | Number of empty entries |
| full | output | 1 | No empty entry |
| wk_valid | input | 1 | Completion broadcast valid |
| wk_reg | input | RW | Register being produced |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQW | Entries younger than this are removed |
| iss_valid | output | W_TOT | Per-slot issue valid |
| iss_seq | output | W_TOT*SEQW | Per-slot sequence number |
| iss_cls | output | W_TOT*2 | Per-slot class code |
| iss_dst | output | W_TOT*RW | Per-slot destination register |

## Verification
Directed sequences come first.

- A producer with no sources shows that a fresh entry waits one cycle before it issues.
- A consumer that is woken in its own insertion cycle separates the same-cycle bypass from the ready-table path.
- A clear and a wakeup of one register in the same cycle shows which of the two wins.
- Filling the queue with a mix of classes that all wait on one register, then waking it, shows the class limits and the branch-integer-float claim on the total width, because the float entries starve while the other classes saturate.
- A squash into the middle of a waiting group separates younger from older survivors.

Three long runs then compare every output each cycle against a behavioural model: insertions with no dependencies, chained dependencies, and frequent squashes. Sequence numbers wrap many times during these runs, which exercises the wrap-safe age compare.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_FP  = 2'd1,
        CLS_BR  = 2'd2
    } iq_cls_e;

    // a is older than b when the modular difference a-b is negative in w bits
    function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b, input int w);
        logic [31:0] d;
        d = a - b;
        return ((d >> (w - 1)) & 32'd1) != 32'd0;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
    parameter int NREG = 64,
    parameter int RW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_reg,
    input  logic [RW-1:0] rd0,
    input  logic [RW-1:0] rd1,
    output logic          rdy0,
    output logic          rdy1
);
    typedef struct packed {
        logic [NREG-1:0] avail;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        if (set_en) sb_d.avail[set_reg] = 1'b1;
        if (clr_en) sb_d.avail[clr_reg] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '{avail: '1};
        else        sb_q <= sb_d;
    end

    assign rdy0 = sb_q.avail[rd0];
    assign rdy1 = sb_q.avail[rd1];
endmodule

// File: rtl/iq_select.sv
module iq_select
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEQW  = 6,
    parameter int W_INT = 2,
    parameter int W_FP  = 1,
    parameter int W_BR  = 1,
    parameter int W_TOT = 3,
    parameter int SLW   = 2
) (
    input  logic [DEPTH-1:0]           req,
    input  logic [DEPTH-1:0][1:0]      cls,
    input  logic [DEPTH-1:0][SEQW-1:0] seq,
    output logic [DEPTH-1:0]           grant,
    output logic [DEPTH-1:0][SLW-1:0]  slot
);
    int rank [DEPTH];
    int cnt  [4];
    int alw  [4];
    int off  [4];
    int n_br, n_int;

    always_comb begin
        for (int c = 0; c < 4; c++) cnt[c] = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rank[i] = 0;
            if (req[i]) cnt[cls[i]] = cnt[cls[i]] + 1;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && req[j] && cls[j] == cls[i] &&
                    seq_older(32'(seq[j]), 32'(seq[i]), SEQW))
                    rank[i] = rank[i] + 1;
            end
        end
        alw[int'(CLS_BR)]  = imin(W_BR, W_TOT);
        n_br               = imin(cnt[int'(CLS_BR)], alw[int'(CLS_BR)]);
        alw[int'(CLS_INT)] = imin(W_INT, W_TOT - n_br);
        n_int              = imin(cnt[int'(CLS_INT)], alw[int'(CLS_INT)]);
        alw[int'(CLS_FP)]  = imin(W_FP, W_TOT - n_br - n_int);
        alw[3]             = 0;
        off[int'(CLS_BR)]  = 0;
        off[int'(CLS_INT)] = n_br;
        off[int'(CLS_FP)]  = n_br + n_int;
        off[3]             = 0;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_grant
        assign grant[g] = req[g] && (rank[g] < alw[cls[g]]);
        assign slot[g]  = SLW'(off[cls[g]] + rank[g]);
    end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W_INT = 2,
    parameter int W_FP  = 1,
    parameter int W_BR  = 1,
    parameter int W_TOT = 3,
    parameter int NREG  = 64,
    parameter int SEQW  = $clog2(DEPTH) + 2,
    parameter int RW    = $clog2(NREG),
    parameter int FW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            in_cls,
    input  logic [SEQW-1:0]       in_seq,
    input  logic                  in_src0_vld,
    input  logic [RW-1:0]         in_src0,
    input  logic                  in_src1_vld,
    input  logic [RW-1:0]         in_src1,
    input  logic                  in_dst_vld,
    input  logic [RW-1:0]         in_dst,
    output logic                  in_ready,
    output logic [FW-1:0]         free_count,
    output logic                  full,
    input  logic                  wk_valid,
    input  logic [RW-1:0]         wk_reg,
    input  logic                  sq_valid,
    input  logic [SEQW-1:0]       sq_seq,
    output logic [W_TOT-1:0]      iss_valid,
    output logic [W_TOT*SEQW-1:0] iss_seq,
    output logic [W_TOT*2-1:0]    iss_cls,
    output logic [W_TOT*RW-1:0]   iss_dst
);
    localparam int SLW = (W_TOT > 1) ? $clog2(W_TOT) : 1;

    typedef struct packed {
        logic            vld;
        logic [1:0]      cls;
        logic [SEQW-1:0] seq;
        logic            r0;
        logic            r1;
        logic [RW-1:0]   s0;
        logic [RW-1:0]   s1;
        logic [RW-1:0]   dst;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] e;
    } st_t;

    st_t st_d, st_q;

    logic [DEPTH-1:0]           req, grant;
    logic [DEPTH-1:0][1:0]      e_cls;
    logic [DEPTH-1:0][SEQW-1:0] e_seq;
    logic [DEPTH-1:0][SLW-1:0]  slot;
    logic                       sb0, sb1, accept;
    int                         n_used;

    always_comb begin
        n_used = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.e[i].vld) n_used = n_used + 1;
            req[i]   = st_q.e[i].vld && st_q.e[i].r0 && st_q.e[i].r1 && !sq_valid;
            e_cls[i] = st_q.e[i].cls;
            e_seq[i] = st_q.e[i].seq;
        end
    end

    assign free_count = FW'(DEPTH - n_used);
    assign full       = (n_used == DEPTH);
    assign in_ready   = !full && !sq_valid;
    assign accept     = in_valid && in_ready;

    iq_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (wk_valid),
        .set_reg (wk_reg),
        .clr_en  (accept && in_dst_vld),
        .clr_reg (in_dst),
        .rd0     (in_src0),
        .rd1     (in_src1),
        .rdy0    (sb0),
        .rdy1    (sb1)
    );

    iq_select #(
        .DEPTH(DEPTH), .SEQW(SEQW), .W_INT(W_INT), .W_FP(W_FP),
        .W_BR(W_BR), .W_TOT(W_TOT), .SLW(SLW)
    ) u_sel (
        .req   (req),
        .cls   (e_cls),
        .seq   (e_seq),
        .grant (grant),
        .slot  (slot)
    );

    always_comb begin
        int ins_idx;
        st_d      = st_q;
        iss_valid = '0;
        iss_seq   = '0;
        iss_cls   = '0;
        iss_dst   = '0;
        ins_idx   = 0;
        for (int s = 0; s < W_TOT; s++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (grant[i] && slot[i] == SLW'(s)) begin
                    iss_valid[s]             = 1'b1;
                    iss_seq[s*SEQW +: SEQW]  = st_q.e[i].seq;
                    iss_cls[s*2 +: 2]        = st_q.e[i].cls;
                    iss_dst[s*RW +: RW]      = st_q.e[i].dst;
                end
            end
        end
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.e[i].vld) ins_idx = i;
            if (grant[i]) st_d.e[i].vld = 1'b0;
            if (sq_valid && st_q.e[i].vld &&
                seq_older(32'(sq_seq), 32'(st_q.e[i].seq), SEQW))
                st_d.e[i].vld = 1'b0;
            if (wk_valid && st_q.e[i].s0 == wk_reg) st_d.e[i].r0 = 1'b1;
            if (wk_valid && st_q.e[i].s1 == wk_reg) st_d.e[i].r1 = 1'b1;
        end
        if (accept) begin
            st_d.e[ins_idx].vld = 1'b1;
            st_d.e[ins_idx].cls = in_cls;
            st_d.e[ins_idx].seq = in_seq;
            st_d.e[ins_idx].s0  = in_src0;
            st_d.e[ins_idx].s1  = in_src1;
            st_d.e[ins_idx].dst = in_dst;
            st_d.e[ins_idx].r0  = !in_src0_vld || sb0 || (wk_valid && wk_reg == in_src0);
            st_d.e[ins_idx].r1  = !in_src1_vld || sb1 || (wk_valid && wk_reg == in_src1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/iq_chk.sv
module iq_chk #(
    parameter int DEPTH = 16,
    parameter int W_INT = 2,
    parameter int W_FP  = 1,
    parameter int W_BR  = 1,
    parameter int W_TOT = 3,
    parameter int FW    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               full,
    input logic [FW-1:0]      free_count,
    input logic               sq_valid,
    input logic [W_TOT-1:0]   iss_valid,
    input logic [W_TOT*2-1:0] iss_cls
);
    int n_iss, n_i, n_f, n_b;

    always_comb begin
        n_iss = 0; n_i = 0; n_f = 0; n_b = 0;
        for (int s = 0; s < W_TOT; s++) begin
            if (iss_valid[s]) begin
                n_iss = n_iss + 1;
                case (iss_cls[s*2 +: 2])
                    2'd0:    n_i = n_i + 1;
                    2'd1:    n_f = n_f + 1;
                    default: n_b = n_b + 1;
                endcase
            end
        end
    end

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready);

    p_accept_takes_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && iss_valid == '0) |=>
        (int'(free_count) == int'($past(free_count)) - 1));

    p_issue_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && in_ready) && !sq_valid) |=>
        (int'(free_count) == int'($past(free_count)) + $past(n_iss)));

    p_squash_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> (iss_valid == '0));

    p_class_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (n_i <= W_INT) && (n_f <= W_FP) && (n_b <= W_BR));

    for (genvar s = 1; s < W_TOT; s++) begin : g_pack
        p_slots_packed_r5: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[s] |-> iss_valid[s-1]);
    end
endmodule

bind issue_queue iq_chk #(
    .DEPTH(DEPTH), .W_INT(W_INT), .W_FP(W_FP), .W_BR(W_BR), .W_TOT(W_TOT), .FW(FW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .full       (full),
    .free_count (free_count),
    .sq_valid   (sq_valid),
    .iss_valid  (iss_valid),
    .iss_cls    (iss_cls)
);

// File: tb/sim_issue_queue.sv
module sim_issue_queue;
    localparam int CLK_PER = 10;
    localparam int DEPTH = 16, W_INT = 2, W_FP = 1, W_BR = 1, W_TOT = 3, NREG = 64;
    localparam int SEQW = 6, RW = 6, FW = 5;
    localparam int SMOD = 1 << SEQW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid, in_src0_vld, in_src1_vld, in_dst_vld, wk_valid, sq_valid;
    logic [1:0] in_cls;
    logic [SEQW-1:0] in_seq, sq_seq;
    logic [RW-1:0] in_src0, in_src1, in_dst, wk_reg;
    logic in_ready, full;
    logic [FW-1:0] free_count;
    logic [W_TOT-1:0] iss_valid;
    logic [W_TOT*SEQW-1:0] iss_seq;
    logic [W_TOT*2-1:0] iss_cls;
    logic [W_TOT*RW-1:0] iss_dst;

    always #(CLK_PER/2) clk = ~clk;

    issue_queue #(.DEPTH(DEPTH), .W_INT(W_INT), .W_FP(W_FP), .W_BR(W_BR),
                  .W_TOT(W_TOT), .NREG(NREG)) u0 (.*);

    // reference model state
    bit m_vld [DEPTH];
    int m_cls [DEPTH], m_seq [DEPTH], m_s0 [DEPTH], m_s1 [DEPTH], m_dst [DEPTH];
    bit m_r0 [DEPTH], m_r1 [DEPTH];
    bit m_sb [NREG];
    bit taken [DEPTH];
    int next_seq;
    int vectors = 0, miscompares = 0;
    bit done = 0;
    string phase = "R1";

    function automatic bit older(int a, int b);
        return ((a - b + SMOD) % SMOD) >= (SMOD / 2);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", tag, phase, what, act, exp, $time);
        end
    endtask

    function automatic int model_count();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (m_vld[i]) n++;
        return n;
    endfunction

    task automatic idle();
        in_valid = 0; in_cls = 0; in_seq = SEQW'(next_seq);
        in_src0_vld = 0; in_src0 = 0; in_src1_vld = 0; in_src1 = 0;
        in_dst_vld = 0; in_dst = 0; wk_valid = 0; wk_reg = 0; sq_valid = 0; sq_seq = 0;
    endtask

    task automatic ins(int c, bit v0, int r0, bit v1, int r1, bit dv, int d);
        in_valid = 1; in_cls = 2'(c); in_seq = SEQW'(next_seq);
        in_src0_vld = v0; in_src0 = RW'(r0); in_src1_vld = v1; in_src1 = RW'(r1);
        in_dst_vld = dv; in_dst = RW'(d);
    endtask

    // compare at negedge+1, then advance the model on the rising edge
    task automatic tick();
        int slot, cnt, e_ready, best, w, c, acc, fi;
        int e_seq [W_TOT], e_cls [W_TOT], e_dst [W_TOT];
        bit e_iv [W_TOT];
        #1;
        vectors++;
        cnt = model_count();
        e_ready = (cnt < DEPTH) && !sq_valid;
        chk("R2", "in_ready", int'(in_ready), e_ready);
        chk("R3", "free_count", int'(free_count), DEPTH - cnt);
        chk("R3", "full", int'(full), int'(cnt == DEPTH));
        for (int i = 0; i < DEPTH; i++) taken[i] = 0;
        for (int s = 0; s < W_TOT; s++) begin e_iv[s] = 0; e_seq[s] = 0; e_cls[s] = 0; e_dst[s] = 0; end
        slot = 0;
        if (!sq_valid) begin
            for (int k = 0; k < 3; k++) begin
                int n;
                c = (k == 0) ? 2 : (k == 1) ? 0 : 1;
                w = (c == 2) ? W_BR : (c == 0) ? W_INT : W_FP;
                n = 0;
                while (n < w && slot < W_TOT) begin
                    best = -1;
                    for (int i = 0; i < DEPTH; i++)
                        if (m_vld[i] && m_r0[i] && m_r1[i] && m_cls[i] == c && !taken[i] &&
                            (best < 0 || older(m_seq[i], m_seq[best]))) best = i;
                    if (best < 0) break;
                    taken[best] = 1;
                    e_iv[slot] = 1; e_seq[slot] = m_seq[best];
                    e_cls[slot] = m_cls[best]; e_dst[slot] = m_dst[best];
                    slot++; n++;
                end
            end
        end
        for (int s = 0; s < W_TOT; s++) begin
            chk("R4 R5", $sformatf("slot%0d valid", s), int'(iss_valid[s]), int'(e_iv[s]));
            if (e_iv[s] && iss_valid[s]) begin
                chk("R5", $sformatf("slot%0d seq", s), int'(iss_seq[s*SEQW +: SEQW]), e_seq[s]);
                chk("R4", $sformatf("slot%0d cls", s), int'(iss_cls[s*2 +: 2]), e_cls[s]);
                chk("R5", $sformatf("slot%0d dst", s), int'(iss_dst[s*RW +: RW]), e_dst[s]);
            end
        end
        acc = in_valid && e_ready;
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            if (taken[i]) m_vld[i] = 0;
            if (sq_valid && m_vld[i] && older(int'(sq_seq), m_seq[i])) m_vld[i] = 0;
            if (wk_valid && m_s0[i] == int'(wk_reg)) m_r0[i] = 1;
            if (wk_valid && m_s1[i] == int'(wk_reg)) m_r1[i] = 1;
        end
        if (acc) begin
            fi = -1;
            for (int i = 0; i < DEPTH; i++) if (!m_vld[i] && !taken[i] && fi < 0) fi = i;
            if (fi < 0) for (int i = 0; i < DEPTH; i++) if (!m_vld[i] && fi < 0) fi = i;
            m_vld[fi] = 1; m_cls[fi] = int'(in_cls); m_seq[fi] = int'(in_seq);
            m_s0[fi] = int'(in_src0); m_s1[fi] = int'(in_src1); m_dst[fi] = int'(in_dst);
            m_r0[fi] = !in_src0_vld || m_sb[in_src0] || (wk_valid && wk_reg == in_src0);
            m_r1[fi] = !in_src1_vld || m_sb[in_src1] || (wk_valid && wk_reg == in_src1);
            next_seq = (next_seq + 1) % SMOD;
        end
        if (wk_valid) m_sb[wk_reg] = 1;
        if (acc && in_dst_vld) m_sb[in_dst] = 0;
        if (sq_valid) next_seq = (int'(sq_seq) + 1) % SMOD;
        @(negedge clk);
    endtask

    task automatic idle_ticks(int n);
        for (int k = 0; k < n; k++) begin idle(); tick(); end
    endtask

    task automatic rand_cycle(int p_ins, int p_wk, int p_sq, int p_src);
        int oldest, pick, start;
        idle();
        oldest = -1;
        for (int i = 0; i < DEPTH; i++)
            if (m_vld[i] && (oldest < 0 || older(m_seq[i], oldest))) oldest = m_seq[i];
        if (($urandom % 100) < p_ins &&
            (oldest < 0 || ((next_seq - oldest + SMOD) % SMOD) < 28))
            ins($urandom % 3, ($urandom % 100) < p_src, $urandom % NREG,
                ($urandom % 100) < p_src, $urandom % NREG, $urandom % 2, $urandom % NREG);
        if (($urandom % 100) < p_wk) begin
            start = $urandom % NREG;
            for (int k = 0; k < NREG; k++) begin
                pick = (start + k) % NREG;
                if (!m_sb[pick]) begin wk_valid = 1; wk_reg = RW'(pick); break; end
            end
        end
        if (($urandom % 100) < p_sq && model_count() > 0) begin
            start = $urandom % DEPTH;
            for (int k = 0; k < DEPTH; k++)
                if (m_vld[(start + k) % DEPTH]) begin
                    sq_valid = 1; sq_seq = SEQW'(m_seq[(start + k) % DEPTH]); break;
                end
        end
        tick();
    endtask

    initial begin
        #(CLK_PER * 190000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
        for (int r = 0; r < NREG; r++) m_sb[r] = 1;
        next_seq = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        chk("R1", "free_count", int'(free_count), DEPTH);
        chk("R1", "full", int'(full), 0);
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "iss_valid", int'(iss_valid), 0);
        @(negedge clk);
        idle_ticks(1);

        // R11 R6: fresh producer waits one cycle; operand-free entry issues next
        phase = "R11 R6";
        ins(0, 0, 0, 0, 0, 1, 7); tick();
        idle_ticks(2);

        // R7 R6: consumer of pending reg 7, then same-cycle wakeup bypass
        phase = "R7 R6";
        ins(1, 0, 0, 0, 0, 1, 7); tick();
        ins(0, 1, 7, 0, 0, 0, 0); tick();
        idle_ticks(2);
        ins(2, 1, 7, 1, 7, 0, 0); wk_valid = 1; wk_reg = 7; tick();
        idle_ticks(3);

        // R8: clear and set of the same register in one cycle leaves it pending
        phase = "R8";
        ins(0, 0, 0, 0, 0, 1, 12); wk_valid = 1; wk_reg = 12; tick();
        ins(0, 1, 12, 0, 0, 0, 0); tick();
        idle_ticks(3);
        idle(); wk_valid = 1; wk_reg = 12; tick();
        idle_ticks(2);

        // R2 R3 R4 R9: fill with mixed classes waiting on reg 20, then drain
        phase = "R2 R3 R4 R9";
        ins(2, 0, 0, 0, 0, 1, 20); tick();
        idle_ticks(1);
        for (int k = 0; k < DEPTH + 2; k++) begin ins(k % 3, 1, 20, 0, 0, 0, 0); tick(); end
        idle_ticks(2);
        idle(); wk_valid = 1; wk_reg = 20; tick();
        idle_ticks(10);

        // R10: squash into the middle of a waiting group, insertion refused meanwhile
        phase = "R10";
        ins(0, 0, 0, 0, 0, 1, 25); tick();
        idle_ticks(1);
        for (int k = 0; k < 6; k++) begin ins(k % 2, 1, 25, 0, 0, 0, 0); tick(); end
        ins(0, 0, 0, 0, 0, 0, 0); sq_valid = 1; sq_seq = SEQW'((next_seq - 4 + SMOD) % SMOD); tick();
        idle_ticks(1);
        idle(); wk_valid = 1; wk_reg = 25; tick();
        idle_ticks(5);

        // random patterns: independent work, dependency chains, frequent squash
        phase = "R4 R5 R7 random-free";
        for (int k = 0; k < 3000; k++) rand_cycle(90, 30, 0, 10);
        phase = "R6 R7 R8 random-deps";
        for (int k = 0; k < 3000; k++) rand_cycle(70, 40, 0, 70);
        phase = "R10 random-squash";
        for (int k = 0; k < 3000; k++) rand_cycle(75, 40, 8, 50);
        idle_ticks(40);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule